// File: doc/BRIEF.md
# Selectable Divided Clock-Enable Generator

This block derives a slow timing strobe for a serial interface from a fast system clock. A chain of divide-by-two stages runs on the system clock. A small rate code chooses one of its taps: a half-rate, quarter-rate or eighth-rate square wave. The chosen tap is registered once more on the system clock. A rising edge of that registered copy produces a clock-enable pulse that is one system clock wide. Downstream logic never uses a derived clock. It runs on the system clock and advances only in cycles where the pulse is high.

A single enable pin controls the block. While the enable is low, the divider, the resynchronization register and the edge-detect register are all held at zero, and the pulse output is forced low. Raising the enable releases that hold on the next system-clock edge. Every divider stage starts in its high half-period, so the first pulse always appears after the same number of edges, whatever rate is chosen. The rate code is captured only while the block is disabled, so a running pulse train never changes period partway through.

The block has no data stream, so it has no valid/ready interface. Every pin is a plain control or status signal. The pulse is a qualifier for downstream logic and has no handshake. A consumer that is busy simply skips that pulse.

Top module: `divclk_enable_gen`

## Requirements
- R1: With a captured rate code of 00, pulses while enabled are exactly 2 system-clock cycles apart.
- R2: With a captured rate code of 01, pulses while enabled are exactly 4 system-clock cycles apart.
- R3: With a captured rate code of 10 or the reserved code 11, pulses while enabled are exactly 8 system-clock cycles apart.
- R4: `tick` is low in every cycle where `en` is low, including the cycle in which `en` falls, and no pulse appears while the block stays disabled.
- R5: Let `en` first be sampled high at clock edge k, after at least one edge where it was sampled low. Then the first pulse is high during the cycle that follows edge k+1, for every rate code.
- R6: `rate_sel` is captured at every clock edge where `en` is sampled low. A change of `rate_sel` while enabled does not alter the pulse period until the block has been disabled for at least one edge.
- R7: Each pulse lasts exactly one system-clock cycle.
- R8: During and after the asynchronous reset, `tick` is low and the captured rate code is 00. Enabling straight out of reset gives the divide-by-2 pulse train whatever `rate_sel` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| en | input | 1 | Block enable; low holds all divider and resync state at zero |
| rate_sel | input | 2 | Rate code: 00 = /2, 01 = /4, 10 = /8, 11 = /8 |
| tick | output | 1 | One-cycle clock-enable pulse on each rising edge of the resynchronized tap |

## Verification
The bench uses the default build: three divider stages and a two-bit rate code. A two-bit code with only three taps means the reserved code 11 can actually be driven, so the clamp onto the deepest tap is exercised. The longest period is eight cycles, so random enable windows of up to forty cycles cover several whole periods at every rate. Those windows also cover short bursts that end before the first pulse or mid-period. Rate changes injected during enabled windows test the capture-only-while-disabled rule against the bench's own model of the captured code.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int unsigned DIV_STAGES = 3;
  localparam int unsigned RATE_W     = 2;

  typedef logic [RATE_W-1:0] rate_t;

  // Map a rate code to a tap index; codes past the last tap clamp onto it.
  function automatic int unsigned tap_index(input int unsigned code,
                                            input int unsigned stages);
    return (code >= stages) ? stages - 1 : code;
  endfunction
endpackage

// File: rtl/dce_rate_latch.sv
module dce_rate_latch #(
  parameter int unsigned RATE_W = dce_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate_in,
  output logic [RATE_W-1:0] rate_q
);
  // Capture only while idle, so a running train keeps its period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rate_q <= '0;
    else if (!run) rate_q <= rate_in;
  end
endmodule

// File: rtl/dce_divider_chain.sv
module dce_divider_chain #(
  parameter int unsigned STAGES = dce_pkg::DIV_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic [STAGES-1:0] taps
);
  // Down-counting toggle chain: from all-zero, the first active edge
  // sets every stage, so each tap starts in its high half-period.
  logic [STAGES-1:0] borrow;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign borrow[k] = 1'b1;
    end else begin : g_next
      assign borrow[k] = borrow[k-1] & ~taps[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         taps[k] <= 1'b0;
      else if (!run)      taps[k] <= 1'b0;
      else if (borrow[k]) taps[k] <= ~taps[k];
    end
  end
endmodule

// File: rtl/dce_tap_resync.sv
module dce_tap_resync #(
  parameter int unsigned STAGES = dce_pkg::DIV_STAGES,
  parameter int unsigned RATE_W = dce_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [STAGES-1:0] taps,
  input  logic [RATE_W-1:0] rate,
  output logic              level
);
  localparam int unsigned IDX_W = (STAGES > 1) ? $clog2(STAGES) : 1;

  logic [IDX_W-1:0] idx;
  logic             picked;

  always_comb begin
    idx    = IDX_W'(dce_pkg::tap_index(32'(rate), STAGES));
    picked = taps[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    level <= 1'b0;
    else if (!run) level <= 1'b0;
    else           level <= picked;
  end
endmodule

// File: rtl/dce_edge_pulse.sv
module dce_edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic level,
  output logic pulse
);
  logic level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    level_d <= 1'b0;
    else if (!run) level_d <= 1'b0;
    else           level_d <= level;
  end

  // Gated by run so a falling enable silences the output at once.
  assign pulse = run & level & ~level_d;
endmodule

// File: rtl/divclk_enable_gen.sv
module divclk_enable_gen #(
  parameter int unsigned STAGES = dce_pkg::DIV_STAGES,
  parameter int unsigned RATE_W = dce_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              tick
);
  logic [RATE_W-1:0] rate_q;
  logic [STAGES-1:0] taps;
  logic              level;

  dce_rate_latch #(.RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(en), .rate_in(rate_sel), .rate_q(rate_q)
  );

  dce_divider_chain #(.STAGES(STAGES)) u_div (
    .clk(clk), .rst_n(rst_n), .run(en), .taps(taps)
  );

  dce_tap_resync #(.STAGES(STAGES), .RATE_W(RATE_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .run(en), .taps(taps), .rate(rate_q), .level(level)
  );

  dce_edge_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .run(en), .level(level), .pulse(tick)
  );
endmodule

// File: rtl/dce_checker.sv
module dce_checker #(
  parameter int unsigned STAGES = dce_pkg::DIV_STAGES,
  parameter int unsigned RATE_W = dce_pkg::RATE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              tick,
  input logic [RATE_W-1:0] rate_q
);
  logic [3:0] gap;
  logic       seen;
  logic [3:0] period;

  always_comb period = 4'(2 << dce_pkg::tap_index(32'(rate_q), STAGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (!en) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= 4'd1;
      seen <= 1'b1;
    end else if (gap != 4'hF) begin
      gap  <= gap + 4'd1;
    end
  end

  // R1, R2, R3: spacing matches the captured rate
  a_r1_interval: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && seen) |-> (gap == period));

  a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);

  a_r5_first_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(en, 2) && !$past(en, 3) && $past(rst_n, 3)) |-> tick);

  a_r6_rate_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(rate_q));

  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  always_comb begin
    if (!rst_n) a_r8_reset_quiet: assert (!tick);
  end
endmodule

bind divclk_enable_gen dce_checker #(.STAGES(STAGES), .RATE_W(RATE_W)) chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .rate_q(rate_q)
);

// File: tb/divclk_enable_gen_test.sv
module divclk_enable_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       tick;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int         n = 0;        // consecutive edges with en high
  logic [1:0] cap = 2'b00;  // model of captured rate code
  logic       prev_tick = 1'b0;
  string      tag_override = "";

  always #5 clk = ~clk;

  divclk_enable_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate_sel), .tick(tick)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n   <= 0;
      cap <= 2'b00;
    end else if (en) begin
      n   <= n + 1;
    end else begin
      n   <= 0;
      cap <= rate_sel;
    end
  end

  function automatic int model_period(input logic [1:0] c);
    return (c >= 2'd2) ? 8 : (c == 2'd1 ? 4 : 2);
  endfunction

  function automatic logic model_tick(input logic r, input logic e,
                                      input int cnt, input logic [1:0] c);
    if (!r || !e || cnt < 2) return 1'b0;
    return ((cnt - 2) % model_period(c)) == 0;
  endfunction

  task automatic check_now();
    logic  exp;
    string tag;
    exp = model_tick(rst_n, en, n, cap);
    if (tag_override != "")   tag = tag_override;
    else if (!rst_n)          tag = "R8";
    else if (!en)             tag = "R4";
    else if (n <= 2)          tag = "R5";
    else if (cap == 2'd0)     tag = "R1";
    else if (cap == 2'd1)     tag = "R2";
    else                      tag = "R3";
    checks++;
    if (tick !== exp) begin
      failures++;
      $display("FAIL %s: tick=%0b expected=%0b (n=%0d code=%0d)", tag, tick, exp, n, cap);
    end
    if (tick === 1'b1) begin
      checks++;
      if (prev_tick !== 1'b0) begin
        failures++;
        $display("FAIL R7: tick high in consecutive cycles, prev=%0b expected=0", prev_tick);
      end
    end
    prev_tick = tick;
  endtask

  task automatic step(input logic e, input logic [1:0] r);
    @(negedge clk);
    check_now();
    en = e;
    rate_sel = r;
  endtask

  task automatic run_rate(input logic [1:0] r, input int len);
    step(1'b0, r);
    step(1'b0, r);
    for (int i = 0; i < len; i++) step(1'b1, r);
    step(1'b0, r);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    // R8: reset state, rate_sel nonzero but captured code must stay 00
    rate_sel = 2'b10;
    en = 1'b1;
    tag_override = "R8";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_now();
    end
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) step(1'b1, 2'b10);
    tag_override = "";
    step(1'b0, 2'b00);
    step(1'b0, 2'b00);

    // R1, R2, R3 directed per code, R5 at each start
    run_rate(2'b00, 20);
    run_rate(2'b01, 30);
    run_rate(2'b10, 40);
    run_rate(2'b11, 40);

    // R4: long disabled stretch
    for (int i = 0; i < 20; i++) step(1'b0, 2'($urandom_range(0, 3)));

    // R6: change code while enabled; old period must persist
    step(1'b0, 2'b01);
    step(1'b0, 2'b01);
    tag_override = "R6";
    for (int i = 0; i < 6; i++) step(1'b1, 2'b01);
    for (int i = 0; i < 24; i++) step(1'b1, 2'b00);
    tag_override = "";
    step(1'b0, 2'b00);
    for (int i = 0; i < 12; i++) step(1'b1, 2'b00);

    // Random windows with mid-run code changes
    for (int t = 0; t < 60; t++) begin
      logic [1:0] r;
      int off_len, on_len;
      r = 2'($urandom_range(0, 3));
      off_len = $urandom_range(1, 4);
      on_len  = $urandom_range(1, 40);
      for (int i = 0; i < off_len; i++) step(1'b0, r);
      for (int i = 0; i < on_len; i++) begin
        if ($urandom_range(0, 9) == 0) r = 2'($urandom_range(0, 3));
        step(1'b1, r);
      end
    end
    step(1'b0, 2'b00);
    step(1'b0, 2'b00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule